// File: doc/BRIEF.md
# Conversion Result Averaging, Offset and Window Compare

This block sits between a sampling converter and the result registers of its conversion groups. Each raw 12-bit sample arrives on a valid strobe, tagged with the group it belongs to. The block can average a run of 4, 8, 16 or 32 consecutive samples, or pass every sample straight through. It then adds or subtracts a user offset with clamping, and checks the adjusted value against one threshold or a pair of thresholds. Only a value that finishes its run and passes the check is stored. Storing it sets the group's completion flag and can raise a one-cycle interrupt and a one-cycle DMA request.

A three-state machine drives the flow. IDLE waits for a sample. GATHER accumulates the samples of an averaging run. JUDGE is the single cycle in which the finished value is adjusted, compared and committed. The transitions are:
- IDLE to JUDGE on a sample with averaging off.
- IDLE to GATHER on a sample with averaging on.
- GATHER to GATHER on any sample except the last of the run.
- GATHER to JUDGE on the last sample.
- JUDGE to IDLE when no sample arrives.
- JUDGE to JUDGE or to GATHER when a sample arrives during the JUDGE cycle. That sample opens the next run.

Top module: `adc_pp_top`

## Requirements
- R1: With averaging off (`avg_sel` of 4 or more) and the compare off, a sample accepted on a rising edge is stored in its group's result field on the next rising edge, with the offset applied, and that edge also sets the group's bit in `done_flags`. Group g's result field is `results[g*12 +: 12]`.
- R2: `avg_sel` codes 0, 1, 2 and 3 select runs of 4, 8, 16 and 32 samples. The group of a run is the group of its first sample. The value processed is the sum of the run shifted right by log2 of the run length. No flag is set before the last sample of the run has been taken.
- R3: The adjusted value is the average plus `ofs_val` when `ofs_sub` is 0, or the average minus `ofs_val` when `ofs_sub` is 1. It is clamped to the range 0 to 4095.
- R4: With `cmp_en` set, `cmp_mode` 0 passes when the adjusted value is below `thr_a`, and `cmp_mode` 1 passes when it is at or above `thr_a`.
- R5: `cmp_mode` 2 passes when the value is below `thr_a` or above `thr_b`, if `thr_a` <= `thr_b`. If `thr_a` > `thr_b`, it passes when the value is below `thr_a` and above `thr_b`.
- R6: `cmp_mode` 3 passes when `thr_a` <= value <= `thr_b`, if `thr_a` <= `thr_b`. If `thr_a` > `thr_b`, it passes when the value is at or above `thr_a` or at or below `thr_b`.
- R7: A value that fails the compare leaves the result field, the flag, `irq` and `dma_req` unchanged or low.
- R8: When a value is stored, `irq` pulses high for one cycle if the `irq_en` bit of its group is set. `dma_req` pulses high for one cycle if `dma_en` is set. Both pulses fall in the cycle in which the flag rises.
- R9: A group's flag is cleared on an edge where its bit in `flag_clr` is 1, or where `rd_en` is high and `rd_grp` names that group.
- R10: With `ovwr_en` low, a value for a group whose flag is still set is discarded. The result field keeps its value and no pulse is raised. With `ovwr_en` high, the new value replaces the old one.
- R11: When a clear and a commit hit the same group on the same edge, the overwrite decision uses the flag as it stood before that edge. If the value is accepted, the flag ends set. If the value is discarded, the flag ends clear.
- R12: After reset, all result fields are 0, all flags are 0, and `irq` and `dma_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_valid | input | 1 | A raw sample is present |
| raw_grp | input | GRP_W | Group of the raw sample |
| raw_data | input | DATA_W | Raw sample value |
| avg_sel | input | 3 | Run length code: 0..3 gives 4/8/16/32 samples, 4..7 turns averaging off |
| cmp_en | input | 1 | Enables the compare gate |
| cmp_mode | input | 2 | Compare rule, 0..3 |
| thr_a | input | DATA_W | First threshold |
| thr_b | input | DATA_W | Second threshold |
| ofs_val | input | DATA_W | Offset magnitude |
| ofs_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| ovwr_en | input | 1 | Allows a new value to replace one whose flag is still set |
| dma_en | input | 1 | Enables the DMA request pulse |
| irq_en | input | NUM_GRP | Per-group interrupt enable |
| flag_clr | input | NUM_GRP | Write-1-to-clear strobe for the flags |
| rd_en | input | 1 | A result field is being read |
| rd_grp | input | GRP_W | Group being read |
| results | output | NUM_GRP*DATA_W | Stored result fields, group 0 in the low bits |
| done_flags | output | NUM_GRP | Per-group completion flags |
| irq | output | 1 | Completion interrupt pulse |
| dma_req | output | 1 | DMA request pulse |

## Verification
A commit from the JUDGE state and a flag clear can land on the same rising edge for the same group. The bench provokes this by raising `flag_clr` in the cycle after a sample is accepted, so the clear lines up with the commit edge. It runs this once with `ovwr_en` low and once with it high. With overwrite off, the bench expects the flag to drop and the stored value to stay. With overwrite on, it expects the flag to stay set and the new value to appear.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

    // Processing flow states
    typedef enum logic [1:0] {
        PP_IDLE   = 2'd0,
        PP_GATHER = 2'd1,
        PP_JUDGE  = 2'd2
    } pp_state_e;

    // Compare rules
    typedef enum logic [1:0] {
        CMP_BELOW   = 2'd0,
        CMP_ATLEAST = 2'd1,
        CMP_OUTSIDE = 2'd2,
        CMP_INSIDE  = 2'd3
    } cmp_mode_e;

endpackage

// File: rtl/adc_pp_gather.sv
module adc_pp_gather
    import adc_pp_pkg::*;
#(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned NUM_GRP = 2,
    parameter int unsigned GRP_W   = 1,
    parameter int unsigned MAX_LOG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [GRP_W-1:0]  smp_grp,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [2:0]        avg_sel,
    output pp_state_e         state_o,
    output logic [GRP_W-1:0]  run_grp,
    output logic [DATA_W-1:0] run_avg
);
    localparam int unsigned SUM_W = DATA_W + MAX_LOG;
    localparam int unsigned CNT_W = MAX_LOG + 1;

    pp_state_e          state_q, state_d;
    logic [SUM_W-1:0]   sum_q;
    logic [CNT_W-1:0]   cnt_q, last_q, run_last;
    logic [2:0]         shift_q, log_k;
    logic [GRP_W-1:0]   grp_q;
    logic               avg_on, start;

    assign avg_on   = (avg_sel[2] == 1'b0);
    assign log_k    = {1'b0, avg_sel[1:0]} + 3'd2;
    assign run_last = avg_on ? ((CNT_W'(1) << log_k) - CNT_W'(1)) : '0;
    assign start    = smp_valid && (state_q != PP_GATHER);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PP_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PP_IDLE, PP_JUDGE: begin
                if (smp_valid) state_d = avg_on ? PP_GATHER : PP_JUDGE;
                else           state_d = PP_IDLE;
            end
            PP_GATHER: begin
                if (smp_valid && (cnt_q == last_q)) state_d = PP_JUDGE;
            end
            default: state_d = PP_IDLE;
        endcase
    end

    // Accumulation datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            cnt_q   <= '0;
            last_q  <= '0;
            shift_q <= '0;
            grp_q   <= '0;
        end else if (start) begin
            sum_q   <= SUM_W'(smp_data);
            cnt_q   <= CNT_W'(1);
            last_q  <= run_last;
            shift_q <= avg_on ? log_k : 3'd0;
            grp_q   <= smp_grp;
        end else if (smp_valid) begin
            sum_q   <= sum_q + SUM_W'(smp_data);
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    assign state_o = state_q;
    assign run_grp = grp_q;
    assign run_avg = DATA_W'(sum_q >> shift_q);

endmodule

// File: rtl/adc_pp_judge.sv
module adc_pp_judge
    import adc_pp_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic [DATA_W-1:0] avg,
    input  logic [DATA_W-1:0] ofs_val,
    input  logic              ofs_sub,
    input  logic              cmp_en,
    input  logic [1:0]        cmp_mode,
    input  logic [DATA_W-1:0] thr_a,
    input  logic [DATA_W-1:0] thr_b,
    output logic [DATA_W-1:0] adj,
    output logic              pass
);
    localparam int unsigned EXT_W = DATA_W + 2;

    logic [EXT_W-1:0] ext_avg, ext_ofs, sum_w;
    logic lt_a, gt_b, ordered, hit;

    assign ext_avg = EXT_W'(avg);
    assign ext_ofs = EXT_W'(ofs_val);
    assign sum_w   = ofs_sub ? (ext_avg - ext_ofs) : (ext_avg + ext_ofs);

    // Clamp: top bit is the borrow of a subtraction, next bit the carry of an addition
    always_comb begin
        if (sum_w[EXT_W-1])      adj = '0;
        else if (sum_w[DATA_W])  adj = '1;
        else                     adj = sum_w[DATA_W-1:0];
    end

    assign lt_a    = (adj < thr_a);
    assign gt_b    = (adj > thr_b);
    assign ordered = (thr_a <= thr_b);

    always_comb begin
        unique case (cmp_mode_e'(cmp_mode))
            CMP_BELOW:   hit = lt_a;
            CMP_ATLEAST: hit = !lt_a;
            CMP_OUTSIDE: hit = ordered ? (lt_a || gt_b)   : (lt_a && gt_b);
            CMP_INSIDE:  hit = ordered ? (!lt_a && !gt_b) : (!lt_a || !gt_b);
            default:     hit = 1'b0;
        endcase
    end

    assign pass = !cmp_en || hit;

endmodule

// File: rtl/adc_pp_store.sv
module adc_pp_store #(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned NUM_GRP = 2,
    parameter int unsigned GRP_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_v,
    input  logic [GRP_W-1:0]          commit_grp,
    input  logic [DATA_W-1:0]         commit_val,
    input  logic                      ovwr_en,
    input  logic                      dma_en,
    input  logic [NUM_GRP-1:0]        irq_en,
    input  logic [NUM_GRP-1:0]        flag_clr,
    input  logic                      rd_en,
    input  logic [GRP_W-1:0]          rd_grp,
    output logic [NUM_GRP*DATA_W-1:0] results,
    output logic [NUM_GRP-1:0]        done_flags,
    output logic                      irq,
    output logic                      dma_req
);
    logic [NUM_GRP-1:0] flag_q, take;
    logic               irq_q, dma_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [DATA_W-1:0] res_q;
        logic              clr;

        assign take[g] = commit_v && (commit_grp == GRP_W'(g)) && (ovwr_en || !flag_q[g]);
        assign clr     = flag_clr[g] || (rd_en && (rd_grp == GRP_W'(g)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
                res_q     <= '0;
            end else begin
                flag_q[g] <= take[g] || (flag_q[g] && !clr);
                if (take[g]) res_q <= commit_val;
            end
        end

        assign results[g*DATA_W +: DATA_W] = res_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            dma_q <= 1'b0;
        end else begin
            irq_q <= |(take & irq_en);
            dma_q <= dma_en && (|take);
        end
    end

    assign done_flags = flag_q;
    assign irq        = irq_q;
    assign dma_req    = dma_q;

endmodule

// File: rtl/adc_pp_top.sv
module adc_pp_top
    import adc_pp_pkg::*;
#(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned NUM_GRP = 2,
    parameter int unsigned MAX_LOG = 5,
    parameter int unsigned GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      raw_valid,
    input  logic [GRP_W-1:0]          raw_grp,
    input  logic [DATA_W-1:0]         raw_data,
    input  logic [2:0]                avg_sel,
    input  logic                      cmp_en,
    input  logic [1:0]                cmp_mode,
    input  logic [DATA_W-1:0]         thr_a,
    input  logic [DATA_W-1:0]         thr_b,
    input  logic [DATA_W-1:0]         ofs_val,
    input  logic                      ofs_sub,
    input  logic                      ovwr_en,
    input  logic                      dma_en,
    input  logic [NUM_GRP-1:0]        irq_en,
    input  logic [NUM_GRP-1:0]        flag_clr,
    input  logic                      rd_en,
    input  logic [GRP_W-1:0]          rd_grp,
    output logic [NUM_GRP*DATA_W-1:0] results,
    output logic [NUM_GRP-1:0]        done_flags,
    output logic                      irq,
    output logic                      dma_req
);
    pp_state_e         st_w;
    logic [GRP_W-1:0]  run_grp_w;
    logic [DATA_W-1:0] run_avg_w, adj_w;
    logic              pass_w, judge_w, commit_w;

    adc_pp_gather #(
        .DATA_W(DATA_W), .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .MAX_LOG(MAX_LOG)
    ) u_gather (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(raw_valid), .smp_grp(raw_grp), .smp_data(raw_data),
        .avg_sel(avg_sel),
        .state_o(st_w), .run_grp(run_grp_w), .run_avg(run_avg_w)
    );

    adc_pp_judge #(.DATA_W(DATA_W)) u_judge (
        .avg(run_avg_w), .ofs_val(ofs_val), .ofs_sub(ofs_sub),
        .cmp_en(cmp_en), .cmp_mode(cmp_mode), .thr_a(thr_a), .thr_b(thr_b),
        .adj(adj_w), .pass(pass_w)
    );

    assign judge_w  = (st_w == PP_JUDGE);
    assign commit_w = judge_w && pass_w;

    adc_pp_store #(
        .DATA_W(DATA_W), .NUM_GRP(NUM_GRP), .GRP_W(GRP_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit_v(commit_w), .commit_grp(run_grp_w), .commit_val(adj_w),
        .ovwr_en(ovwr_en), .dma_en(dma_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .rd_en(rd_en), .rd_grp(rd_grp),
        .results(results), .done_flags(done_flags), .irq(irq), .dma_req(dma_req)
    );

endmodule

// File: rtl/adc_pp_checker.sv
module adc_pp_checker #(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned NUM_GRP = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      judge,
    input logic                      ovwr_en,
    input logic                      dma_en,
    input logic [NUM_GRP*DATA_W-1:0] results,
    input logic [NUM_GRP-1:0]        done_flags,
    input logic                      irq,
    input logic                      dma_req
);
    // R8: an interrupt pulse coincides with a set flag
    assert_irq_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flags != '0));

    // R8: a DMA pulse follows an enabled DMA request
    assert_dma_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(dma_en));

    // R2: a flag only rises right after a JUDGE cycle
    assert_flag_rise_after_judge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_flags & ~$past(done_flags)) != '0) |-> $past(judge));

    // R7: results change only after a JUDGE cycle
    assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(judge) |-> $stable(results));

    // R10: all flags set and overwrite off keeps every result
    assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ovwr_en) && ($past(done_flags) == {NUM_GRP{1'b1}})) |-> $stable(results));

endmodule

bind adc_pp_top adc_pp_checker #(.DATA_W(DATA_W), .NUM_GRP(NUM_GRP)) u_chk (
    .clk(clk), .rst_n(rst_n), .judge(judge_w), .ovwr_en(ovwr_en), .dma_en(dma_en),
    .results(results), .done_flags(done_flags), .irq(irq), .dma_req(dma_req)
);

// File: tb/sim_adc_pp_top.sv
module sim_adc_pp_top;
    localparam int DW = 12;
    localparam int NG = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          raw_valid = 1'b0;
    logic [0:0]    raw_grp = '0;
    logic [DW-1:0] raw_data = '0;
    logic [2:0]    avg_sel = 3'd4;
    logic          cmp_en = 1'b0;
    logic [1:0]    cmp_mode = '0;
    logic [DW-1:0] thr_a = '0, thr_b = '0, ofs_val = '0;
    logic          ofs_sub = 1'b0, ovwr_en = 1'b0, dma_en = 1'b0;
    logic [NG-1:0] irq_en = '0, flag_clr = '0;
    logic          rd_en = 1'b0;
    logic [0:0]    rd_grp = '0;
    logic [NG*DW-1:0] results;
    logic [NG-1:0] done_flags;
    logic          irq, dma_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    adc_pp_top u0 (
        .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_grp(raw_grp),
        .raw_data(raw_data), .avg_sel(avg_sel), .cmp_en(cmp_en), .cmp_mode(cmp_mode),
        .thr_a(thr_a), .thr_b(thr_b), .ofs_val(ofs_val), .ofs_sub(ofs_sub),
        .ovwr_en(ovwr_en), .dma_en(dma_en), .irq_en(irq_en), .flag_clr(flag_clr),
        .rd_en(rd_en), .rd_grp(rd_grp), .results(results), .done_flags(done_flags),
        .irq(irq), .dma_req(dma_req)
    );

    function automatic int res(int g);
        return int'(results[g*DW +: DW]);
    endfunction

    function automatic int cmp_model(int mode, int a, int b, int v);
        if (mode == 0) return (v < a) ? 1 : 0;
        if (mode == 1) return (v >= a) ? 1 : 0;
        if (mode == 2) begin
            if (a <= b) return (v < a || v > b) ? 1 : 0;
            return (v < a && v > b) ? 1 : 0;
        end
        if (a <= b) return (v >= a && v <= b) ? 1 : 0;
        return (v >= a || v <= b) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(int g, int d);
        @(negedge clk);
        raw_grp = 1'(g); raw_data = DW'(d); raw_valid = 1'b1;
        @(negedge clk);
        raw_valid = 1'b0;
    endtask

    task automatic push_wait(int g, int d);
        push(g, d);
        @(negedge clk);
    endtask

    task automatic clr(int mask);
        @(negedge clk);
        flag_clr = NG'(mask);
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic t_reset();
        chk("R12 flags", int'(done_flags), 0);
        chk("R12 res0", res(0), 0);
        chk("R12 res1", res(1), 0);
        chk("R12 irq", int'(irq), 0);
        chk("R12 dma", int'(dma_req), 0);
    endtask

    task automatic t_plain();
        push_wait(0, 'h123);
        chk("R1 res0", res(0), 'h123);
        chk("R1 flag0", int'(done_flags), 1);
        clr(1);
        chk("R9 w1c", int'(done_flags), 0);
        push_wait(1, 'hABC);
        chk("R1 res1", res(1), 'hABC);
        chk("R1 flag1", int'(done_flags), 2);
        @(negedge clk); rd_en = 1'b1; rd_grp = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk("R9 read clear", int'(done_flags), 0);
    endtask

    task automatic ofs_case(int sub, int o, int v, int exp);
        ofs_sub = sub[0]; ofs_val = DW'(o);
        push_wait(0, v);
        chk("R3 offset", res(0), exp);
        clr(3);
    endtask

    task automatic t_offset();
        ofs_case(0, 100, 4050, 4095);
        ofs_case(1, 100, 50, 0);
        ofs_case(0, 5, 10, 15);
        ofs_case(1, 5, 10, 5);
        ofs_sub = 1'b0; ofs_val = '0;
    endtask

    task automatic t_avg();
        int s;
        avg_sel = 3'd0;
        push(1, 10); push(1, 11); push(1, 12);
        @(negedge clk);
        chk("R2 no flag mid run", int'(done_flags), 0);
        push(0, 14);  // group stays 1 from the first sample
        @(negedge clk);
        chk("R2 avg4 res1", res(1), 11);
        chk("R2 avg4 flag", int'(done_flags), 2);
        clr(3);
        avg_sel = 3'd3; s = 0;
        for (int i = 0; i < 32; i++) begin
            push(0, i * 100);
            s += i * 100;
        end
        @(negedge clk);
        chk("R2 avg32 res0", res(0), s / 32);
        clr(3);
        avg_sel = 3'd1;
        for (int i = 0; i < 8; i++) push(0, 4095);
        @(negedge clk);
        chk("R2 avg8 full scale", res(0), 4095);
        clr(3);
        avg_sel = 3'd4;
    endtask

    task automatic cmp_case(string req, int mode, int a, int b, int v);
        int prev, exp;
        cmp_en = 1'b1; cmp_mode = 2'(mode); thr_a = DW'(a); thr_b = DW'(b);
        irq_en = 2'b01;
        prev = res(0);
        exp = cmp_model(mode, a, b, v);
        push_wait(0, v);
        chk(req, int'(done_flags[0]), exp);
        chk(req, int'(irq), exp);
        chk(req, res(0), (exp == 1) ? v : prev);
        clr(3);
    endtask

    task automatic t_cmp();
        cmp_case("R4 m0 pass", 0, 100, 0, 99);
        cmp_case("R4 m0 fail R7", 0, 100, 0, 100);
        cmp_case("R4 m1 pass", 1, 100, 0, 100);
        cmp_case("R4 m1 fail R7", 1, 100, 0, 99);
        cmp_case("R5 ord low", 2, 100, 200, 50);
        cmp_case("R5 ord mid", 2, 100, 200, 150);
        cmp_case("R5 ord high", 2, 100, 200, 201);
        cmp_case("R5 ord edge", 2, 100, 200, 200);
        cmp_case("R5 rev mid", 2, 200, 100, 150);
        cmp_case("R5 rev low", 2, 200, 100, 50);
        cmp_case("R5 rev high", 2, 200, 100, 250);
        cmp_case("R6 ord lo edge", 3, 100, 200, 100);
        cmp_case("R6 ord hi edge", 3, 100, 200, 200);
        cmp_case("R6 ord above", 3, 100, 200, 201);
        cmp_case("R6 ord below", 3, 100, 200, 99);
        cmp_case("R6 rev high", 3, 200, 100, 250);
        cmp_case("R6 rev low", 3, 200, 100, 50);
        cmp_case("R6 rev mid", 3, 200, 100, 150);
        // averaging and compare together: average 20 fails "below 10"
        avg_sel = 3'd0; cmp_mode = 2'd0; thr_a = DW'(10);
        for (int i = 0; i < 4; i++) push(0, 20);
        @(negedge clk);
        chk("R7 avg plus cmp fail", int'(done_flags), 0);
        avg_sel = 3'd4; cmp_en = 1'b0; irq_en = '0;
    endtask

    task automatic t_irq_dma();
        irq_en = 2'b10; dma_en = 1'b1;
        push_wait(1, 7);
        chk("R8 irq g1", int'(irq), 1);
        chk("R8 dma g1", int'(dma_req), 1);
        @(negedge clk);
        chk("R8 irq one cycle", int'(irq), 0);
        chk("R8 dma one cycle", int'(dma_req), 0);
        push_wait(0, 8);
        chk("R8 irq masked", int'(irq), 0);
        chk("R8 dma g0", int'(dma_req), 1);
        clr(3);
        dma_en = 1'b0;
        push_wait(0, 9);
        chk("R8 dma off", int'(dma_req), 0);
        clr(3);
        irq_en = '0;
    endtask

    task automatic t_overwrite();
        ovwr_en = 1'b0; irq_en = 2'b01; dma_en = 1'b1;
        push_wait(0, 'h111);
        push_wait(0, 'h222);
        chk("R10 kept", res(0), 'h111);
        chk("R10 no irq", int'(irq), 0);
        chk("R10 no dma", int'(dma_req), 0);
        ovwr_en = 1'b1;
        push_wait(0, 'h333);
        chk("R10 replaced", res(0), 'h333);
        clr(3);
        irq_en = '0; dma_en = 1'b0;
    endtask

    task automatic t_collide();
        ovwr_en = 1'b0;
        push_wait(0, 'h0AA);
        @(negedge clk); raw_grp = 1'b0; raw_data = DW'('h0BB); raw_valid = 1'b1;
        @(negedge clk); raw_valid = 1'b0; flag_clr = 2'b01;
        @(negedge clk); flag_clr = '0;
        chk("R11 discard flag", int'(done_flags[0]), 0);
        chk("R11 discard res", res(0), 'h0AA);
        push_wait(0, 'h0CC);
        ovwr_en = 1'b1;
        @(negedge clk); raw_data = DW'('h0DD); raw_valid = 1'b1;
        @(negedge clk); raw_valid = 1'b0; flag_clr = 2'b01;
        @(negedge clk); flag_clr = '0;
        chk("R11 set wins flag", int'(done_flags[0]), 1);
        chk("R11 set wins res", res(0), 'h0DD);
        clr(3);
        ovwr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_offset();
        t_avg();
        t_cmp();
        t_irq_dma();
        t_overwrite();
        t_collide();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule